// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KB window of 32-bit control and status words. It sits on a simple single-cycle peripheral port with a select, a write strobe, a word address, write data and registered read data. The words hold:

- a secure-debug status word, with a write-1-to-set alias and a write-1-to-clear alias;
- a reset cause word and a reset mask;
- a retention word that only a power-on reset clears;
- two per-core initial vector-table base words;
- a per-core hold word that releases cores;
- wake and power-sense words;
- twelve read-only identification words.

The block drives three kinds of output. It issues a one-cycle system reset request. It issues a one-cycle start pulse for each core that is released. It presents the two vector base values continuously.

A 32-bit version parameter selects the variant. When its top nibble equals 2, the extended words are present. Otherwise those offsets read zero and refuse writes. Every unmapped offset and every access in the wrong direction raises a one-cycle error flag. Byte and halfword accesses reach the block as full-word accesses, so the two low address bits are ignored.

Top module: `sysctl_regbank`

## Requirements
- R1: After `por_rst` the following hold. The reset cause word (0x100) reads 1 and the system power-sense word (0x200) reads 0x7F when extended. The vector base words (0x110, 0x114) hold their reset parameters and the hold word (0x118) holds its reset parameter. Every other word reads 0, and `swrst_req`, `core_start`, `bus_err` and `bus_rdata` are 0.
- R2: A write to a read/write word stores all 32 bits on the clock edge. A read returns the stored value on `bus_rdata` in the cycle after the request, and `bus_rdata` is 0 in any cycle that follows no valid read. Address bits [1:0] are ignored.
- R3: The status word at 0x000 is read-only. A write to 0x004 ORs the data into it, and a write to 0x008 clears each bit written as 1.
- R4: A write to 0x108 with bit 9 set raises `swrst_req` for exactly the next cycle. Other bits of that write have no effect, and the word stores nothing.
- R5: A write to the hold word at 0x118 pulses `core_start[k]` for one cycle when bit k was 1 before the write and is 0 in the written data (k = 0, 1). The new value is then stored.
- R6: `vtor0` and `vtor1` present the stored vector base words of core 0 and core 1, and they change only after a write or a reset. `vtor1` is 0 in the base variant.
- R7: The words at 0xFD0 to 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R8: With the top nibble of `SYS_VERSION` not equal to 2, the following offsets read 0, ignore writes and flag an error: 0x00C, 0x010, 0x014, 0x018, 0x114, 0x124, 0x200 and 0x20C to 0x218. Offset 0x11C reads 0 without an error and flags an error on writes.
- R9: `bus_err` pulses in the cycle after any of these accesses: an access to an unmapped offset, a read of 0x004, 0x008 or 0x108, or a write to a read-only word. Such a read returns 0 and such a write changes nothing.
- R10: `warm_rst` restores every word except the retention word (0x10C) to its reset value, and it drops any other write in the same cycle. A retention write in that cycle still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high, spares the retention word |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for a bad offset or wrong-direction access |
| swrst_req | output | 1 | One-cycle system reset request |
| core_start | output | 2 | One-cycle power-on-and-reset pulse per core |
| vtor0 | output | 32 | Initial vector base for core 0 |
| vtor1 | output | 32 | Initial vector base for core 1 |

## Verification
The functions that collide are the warm reset and a bus write arriving in the same cycle. The warm reset must win for every word except the retention word, whose write must still land. The bench drives `warm_rst` high together with a write to the retention word, and then together with a write to the reset mask. It judges the result by sweeping reads over the whole map and checking that each word against its reset value, except the retention word, which must hold the written data. A second collision is a write to the hold word that clears some bits while others stay set. Every old/new pair of the two release bits is applied, and the start pulses must equal old AND NOT new.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W  = 32;
  localparam int WORD_W  = 10;
  localparam int ADDR_W  = WORD_W + 2;
  localparam int N_CORES = 2;
  localparam int PS_N    = 5;

  localparam logic [WORD_W-1:0] W_ID_FIRST = 10'h3F4;

  typedef enum logic [4:0] {
    RG_NONE, RG_DBG_STAT, RG_DBG_SET, RG_DBG_CLR, RG_SEC_CTL,
    RG_FCLK_DIV, RG_SCLK_DIV, RG_CLK_FORCE, RG_CAUSE, RG_RST_MASK,
    RG_SW_RESET, RG_RETAIN, RG_VTOR0, RG_VTOR1, RG_HOLD,
    RG_NMI_EN, RG_WAKE, RG_EXT_WAKE, RG_PSENSE, RG_ID
  } reg_id_e;

  function automatic logic [DATA_W-1:0] id_word(input logic [3:0] k);
    logic [7:0] b;
    case (k)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h54;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return {24'h0, b};
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output reg_id_e           id,
  output logic [2:0]        ps_idx,
  output logic              rd_ok,
  output logic              wr_ok
);

  reg_id_e raw_id;
  logic    is_ext, ro, wo, zero_ro;

  always_comb begin
    raw_id = RG_NONE;
    is_ext = 1'b0;
    ro     = 1'b0;
    wo     = 1'b0;
    ps_idx = 3'd0;
    case (word)
      10'h000: begin raw_id = RG_DBG_STAT; ro = 1'b1; end
      10'h001: begin raw_id = RG_DBG_SET;  wo = 1'b1; end
      10'h002: begin raw_id = RG_DBG_CLR;  wo = 1'b1; end
      10'h003: begin raw_id = RG_SEC_CTL;   is_ext = 1'b1; end
      10'h004: begin raw_id = RG_FCLK_DIV;  is_ext = 1'b1; end
      10'h005: begin raw_id = RG_SCLK_DIV;  is_ext = 1'b1; end
      10'h006: begin raw_id = RG_CLK_FORCE; is_ext = 1'b1; end
      10'h040: raw_id = RG_CAUSE;
      10'h041: raw_id = RG_RST_MASK;
      10'h042: begin raw_id = RG_SW_RESET; wo = 1'b1; end
      10'h043: raw_id = RG_RETAIN;
      10'h044: raw_id = RG_VTOR0;
      10'h045: begin raw_id = RG_VTOR1;    is_ext = 1'b1; end
      10'h046: raw_id = RG_HOLD;
      10'h047: begin raw_id = RG_NMI_EN;   is_ext = 1'b1; end
      10'h048: raw_id = RG_WAKE;
      10'h049: begin raw_id = RG_EXT_WAKE; is_ext = 1'b1; end
      10'h080: begin raw_id = RG_PSENSE; is_ext = 1'b1; ps_idx = 3'd0; end
      10'h083: begin raw_id = RG_PSENSE; is_ext = 1'b1; ps_idx = 3'd1; end
      10'h084: begin raw_id = RG_PSENSE; is_ext = 1'b1; ps_idx = 3'd2; end
      10'h085: begin raw_id = RG_PSENSE; is_ext = 1'b1; ps_idx = 3'd3; end
      10'h086: begin raw_id = RG_PSENSE; is_ext = 1'b1; ps_idx = 3'd4; end
      default: if (word >= W_ID_FIRST) begin raw_id = RG_ID; ro = 1'b1; end
    endcase
  end

  // Hidden extended words vanish; the NMI word degrades to a read-only zero.
  always_comb begin
    id      = raw_id;
    zero_ro = 1'b0;
    if (is_ext && !EXT_EN) begin
      id      = RG_NONE;
      zero_ro = (raw_id == RG_NMI_EN);
    end
    rd_ok = !wo && ((id != RG_NONE) || zero_ro);
    wr_ok = (id != RG_NONE) && !ro && !zero_ro;
  end

endmodule

// File: rtl/sysctl_core_hold.sv
module sysctl_core_hold
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hold_q,
  output logic [N_CORES-1:0] start
);

  always_ff @(posedge clk) begin
    if (por_rst || warm_rst) hold_q <= RST_VAL;
    else if (wr_en)          hold_q <= wdata;
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    always_ff @(posedge clk) begin
      if (por_rst || warm_rst) start[k] <= 1'b0;
      else                     start[k] <= wr_en && hold_q[k] && !wdata[k];
    end

    // R5
    release_on_fall_chk: assert property (@(posedge clk) disable iff (por_rst)
      start[k] |-> ($past(hold_q[k]) && !hold_q[k]));
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] SYS_VERSION = 32'h2000_0000,
  parameter logic [31:0] VTOR0_RST   = 32'h1000_0000,
  parameter logic [31:0] VTOR1_RST   = 32'h1000_0000,
  parameter logic [31:0] HOLD_RST    = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               por_rst,
  input  logic               warm_rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               swrst_req,
  output logic [N_CORES-1:0] core_start,
  output logic [DATA_W-1:0]  vtor0,
  output logic [DATA_W-1:0]  vtor1
);

  localparam bit EXT_EN = (SYS_VERSION[31:28] == 4'd2);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] id_off;
  logic              unused_bits;
  reg_id_e           dec_id;
  logic [2:0]        ps_idx;
  logic              rd_ok, wr_ok, wr_any, wr_en;

  assign word        = bus_addr[ADDR_W-1:2];
  assign id_off      = word - W_ID_FIRST;
  assign unused_bits = ^{bus_addr[1:0], id_off[WORD_W-1:4]};

  sysctl_decode #(.EXT_EN(EXT_EN)) u_decode (
    .word(word), .id(dec_id), .ps_idx(ps_idx), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  assign wr_any = bus_sel && bus_wr && wr_ok;
  assign wr_en  = wr_any && !warm_rst;

  logic [DATA_W-1:0] dbg_q, sec_q, fdiv_q, sdiv_q, cforce_q, cause_q, mask_q;
  logic [DATA_W-1:0] retain_q, vtor0_q, vtor1_q, nmi_q, wake_q, ewake_q, hold_q;
  logic [DATA_W-1:0] ps_q [PS_N];

  always_ff @(posedge clk) begin
    if (por_rst || warm_rst) begin
      dbg_q    <= '0;
      sec_q    <= '0;
      fdiv_q   <= '0;
      sdiv_q   <= '0;
      cforce_q <= '0;
      cause_q  <= 32'd1;
      mask_q   <= '0;
      vtor0_q  <= VTOR0_RST;
      vtor1_q  <= VTOR1_RST;
      nmi_q    <= '0;
      wake_q   <= '0;
      ewake_q  <= '0;
    end else if (wr_en) begin
      case (dec_id)
        RG_DBG_SET:   dbg_q    <= dbg_q | bus_wdata;
        RG_DBG_CLR:   dbg_q    <= dbg_q & ~bus_wdata;
        RG_SEC_CTL:   sec_q    <= bus_wdata;
        RG_FCLK_DIV:  fdiv_q   <= bus_wdata;
        RG_SCLK_DIV:  sdiv_q   <= bus_wdata;
        RG_CLK_FORCE: cforce_q <= bus_wdata;
        RG_CAUSE:     cause_q  <= bus_wdata;
        RG_RST_MASK:  mask_q   <= bus_wdata;
        RG_VTOR0:     vtor0_q  <= bus_wdata;
        RG_VTOR1:     vtor1_q  <= bus_wdata;
        RG_NMI_EN:    nmi_q    <= bus_wdata;
        RG_WAKE:      wake_q   <= bus_wdata;
        RG_EXT_WAKE:  ewake_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // Retention word: only power-on reset clears it; writes land even under warm reset.
  always_ff @(posedge clk) begin
    if (por_rst)                           retain_q <= '0;
    else if (wr_any && dec_id == RG_RETAIN) retain_q <= bus_wdata;
  end

  for (genvar i = 0; i < PS_N; i++) begin : g_ps
    localparam logic [DATA_W-1:0] PS_RST = (i == 0) ? 32'h7F : 32'h0;
    always_ff @(posedge clk) begin
      if (por_rst || warm_rst)                                    ps_q[i] <= PS_RST;
      else if (wr_en && dec_id == RG_PSENSE && ps_idx == 3'(i))   ps_q[i] <= bus_wdata;
    end
  end

  sysctl_core_hold #(.RST_VAL(HOLD_RST)) u_hold (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst),
    .wr_en(wr_en && dec_id == RG_HOLD), .wdata(bus_wdata),
    .hold_q(hold_q), .start(core_start)
  );

  logic [DATA_W-1:0] rmux;
  always_comb begin
    case (dec_id)
      RG_DBG_STAT:  rmux = dbg_q;
      RG_SEC_CTL:   rmux = sec_q;
      RG_FCLK_DIV:  rmux = fdiv_q;
      RG_SCLK_DIV:  rmux = sdiv_q;
      RG_CLK_FORCE: rmux = cforce_q;
      RG_CAUSE:     rmux = cause_q;
      RG_RST_MASK:  rmux = mask_q;
      RG_RETAIN:    rmux = retain_q;
      RG_VTOR0:     rmux = vtor0_q;
      RG_VTOR1:     rmux = vtor1_q;
      RG_HOLD:      rmux = hold_q;
      RG_NMI_EN:    rmux = nmi_q;
      RG_WAKE:      rmux = wake_q;
      RG_EXT_WAKE:  rmux = ewake_q;
      RG_PSENSE:    rmux = ps_q[ps_idx];
      RG_ID:        rmux = id_word(id_off[3:0]);
      default:      rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      swrst_req <= 1'b0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr && rd_ok) ? rmux : '0;
      bus_err   <= bus_sel && (bus_wr ? !wr_ok : !rd_ok);
      swrst_req <= wr_en && dec_id == RG_SW_RESET && bus_wdata[9];
    end
  end

  assign vtor0 = vtor0_q;
  assign vtor1 = EXT_EN ? vtor1_q : '0;

  // R4
  swrst_source_chk: assert property (@(posedge clk) disable iff (por_rst)
    swrst_req |-> $past(bus_sel && bus_wr && bus_wdata[9] && !warm_rst));

  // R3
  dbg_set_needs_write_chk: assert property (@(posedge clk) disable iff (por_rst)
    (|(dbg_q & ~$past(dbg_q))) |-> $past(bus_sel && bus_wr));

  // R6
  vtor_quiet_chk: assert property (@(posedge clk) disable iff (por_rst)
    (!$past(bus_sel && bus_wr) && !$past(warm_rst)) |-> ($stable(vtor0) && $stable(vtor1)));

  // R10
  retain_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
    !$past(bus_sel && bus_wr) |-> $stable(retain_q));

  // R9
  err_reads_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
    bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;

  localparam logic [31:0] A_VER = 32'h2041_0000, B_VER = 32'h1000_0000;
  localparam logic [31:0] A_V0 = 32'h1000_0000, A_V1 = 32'h2000_0400, A_HOLD = 32'h3;
  localparam logic [31:0] B_V0 = 32'h0800_0000, B_V1 = 32'h3000_0000, B_HOLD = 32'h0;

  localparam int K_NONE = 0, K_RW = 1, K_RO = 2, K_SET = 3, K_CLR = 4, K_SWR = 5, K_HOLD = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_rst = 1'b1, warm_a = 1'b0, warm_b = 1'b0, sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b, v0_a, v1_a, v0_b, v1_b;
  logic err_a, err_b, sw_a, sw_b;
  logic [1:0] cs_a, cs_b;

  int vectors = 0, miscompares = 0;
  logic [31:0] m [2][1024];

  sysctl_regbank #(.SYS_VERSION(A_VER), .VTOR0_RST(A_V0), .VTOR1_RST(A_V1), .HOLD_RST(A_HOLD))
  i_sysctl_regbank (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_a), .bus_sel(sel_a), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_a), .bus_err(err_a),
    .swrst_req(sw_a), .core_start(cs_a), .vtor0(v0_a), .vtor1(v1_a)
  );

  sysctl_regbank #(.SYS_VERSION(B_VER), .VTOR0_RST(B_V0), .VTOR1_RST(B_V1), .HOLD_RST(B_HOLD))
  i_sysctl_regbank_base (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_b), .bus_sel(sel_b), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_b), .bus_err(err_b),
    .swrst_req(sw_b), .core_start(cs_b), .vtor0(v0_b), .vtor1(v1_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit is_ext_word(input int w);
    return (w >= 3 && w <= 6) || w == 'h45 || w == 'h47 || w == 'h49 || w == 'h80 ||
           (w >= 'h83 && w <= 'h86);
  endfunction

  function automatic int kind(input int w, input bit ext);
    if (is_ext_word(w) && !ext) return (w == 'h47) ? K_RO : K_NONE;
    if (w == 0 || w >= 'h3F4) return K_RO;
    if (w == 1) return K_SET;
    if (w == 2) return K_CLR;
    if (w == 'h42) return K_SWR;
    if (w == 'h46) return K_HOLD;
    if (is_ext_word(w) || w == 'h40 || w == 'h41 || w == 'h43 || w == 'h44 || w == 'h48) return K_RW;
    return K_NONE;
  endfunction

  function automatic logic [31:0] rst_val(input int inst, input int w);
    bit ext = (inst == 0);
    logic [7:0] ids [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8, 8'h0B, 8'h00,
                             8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (w >= 'h3F4) return {24'h0, ids[w - 'h3F4]};
    if (w == 'h40) return 32'd1;
    if (w == 'h80) return ext ? 32'h7F : 32'h0;
    if (w == 'h44) return ext ? A_V0 : B_V0;
    if (w == 'h45) return ext ? A_V1 : 32'h0;
    if (w == 'h46) return ext ? A_HOLD : B_HOLD;
    return 32'h0;
  endfunction

  task automatic model_reset(input int inst, input bit keep_retain);
    for (int w = 0; w < 1024; w++)
      if (!(keep_retain && w == 'h43)) m[inst][w] = rst_val(inst, w);
  endtask

  function automatic string tag_of(input int w, input bit ext);
    int k = kind(w, ext);
    if (w >= 'h3F4) return "R7";
    if (is_ext_word(w) && !ext) return "R8";
    if (k == K_NONE || k == K_SET || k == K_CLR || k == K_SWR) return "R9";
    if (w == 0) return "R3";
    return "R2";
  endfunction

  task automatic check_vtor(input int inst);
    chk(((inst == 0) ? v0_a : v0_b) == m[inst]['h44], "R6 vtor0",
        (inst == 0) ? v0_a : v0_b, m[inst]['h44]);
    chk(((inst == 0) ? v1_a : v1_b) == m[inst]['h45], "R6 vtor1",
        (inst == 0) ? v1_a : v1_b, m[inst]['h45]);
  endtask

  task automatic do_read(input int inst, input int w, input string req);
    bit ext = (inst == 0);
    int k = kind(w, ext);
    bit exp_err = (k == K_NONE || k == K_SET || k == K_CLR || k == K_SWR);
    logic [31:0] act;
    logic act_err;
    @(negedge clk);
    sel_a = (inst == 0); sel_b = (inst == 1); wr = 1'b0;
    addr  = {w[9:0], w[1:0]};
    @(negedge clk);
    act     = (inst == 0) ? rd_a : rd_b;
    act_err = (inst == 0) ? err_a : err_b;
    sel_a = 1'b0; sel_b = 1'b0;
    chk(act == m[inst][w] && act_err == exp_err, req, act, m[inst][w]);
  endtask

  task automatic do_write(input int inst, input int w, input logic [31:0] p, input bit warm);
    bit ext = (inst == 0);
    int k = kind(w, ext);
    bit exp_err = (k == K_NONE || k == K_RO);
    bit exp_sw = 1'b0;
    logic [1:0] exp_cs = 2'b00;
    if (warm) begin
      model_reset(inst, 1'b1);
      if (w == 'h43) m[inst][w] = p;
    end else begin
      case (k)
        K_RW:   m[inst][w] = p;
        K_SET:  m[inst][0] = m[inst][0] | p;
        K_CLR:  m[inst][0] = m[inst][0] & ~p;
        K_SWR:  exp_sw = p[9];
        K_HOLD: begin exp_cs = m[inst][w][1:0] & ~p[1:0]; m[inst][w] = p; end
        default: ;
      endcase
    end
    @(negedge clk);
    sel_a = (inst == 0); sel_b = (inst == 1); wr = 1'b1;
    warm_a = warm && (inst == 0); warm_b = warm && (inst == 1);
    addr  = {w[9:0], w[1:0]};
    wdata = p;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0; warm_a = 1'b0; warm_b = 1'b0;
    chk(((inst == 0) ? err_a : err_b) == exp_err, (w >= 'h3F4) ? "R7 write err" : "R9 write err",
        32'((inst == 0) ? err_a : err_b), 32'(exp_err));
    chk(((inst == 0) ? sw_a : sw_b) == exp_sw, warm ? "R10 swrst" : "R4 swrst",
        32'((inst == 0) ? sw_a : sw_b), 32'(exp_sw));
    chk(((inst == 0) ? cs_a : cs_b) == exp_cs, warm ? "R10 start" : "R5 start",
        32'((inst == 0) ? cs_a : cs_b), 32'(exp_cs));
    check_vtor(inst);
  endtask

  task automatic read_all(input int inst, input string req_override);
    for (int w = 0; w < 1024; w++)
      do_read(inst, w, (req_override != "") ? req_override : tag_of(w, inst == 0));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset(0, 1'b0);
    model_reset(1, 1'b0);
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    @(negedge clk);
    // R1: outputs after power-on reset
    chk(rd_a == 0 && err_a == 0 && sw_a == 0 && cs_a == 0, "R1 outputs", {rd_a[29:0], err_a, sw_a}, 0);
    chk(rd_b == 0 && err_b == 0 && sw_b == 0 && cs_b == 0, "R1 outputs base", {rd_b[29:0], err_b, sw_b}, 0);
    for (int i = 0; i < 2; i++) begin
      check_vtor(i);
      read_all(i, "R1 reset value");
    end

    // Write sweep over every word with an arithmetic pattern, then read back.
    for (int i = 0; i < 2; i++) begin
      for (int w = 0; w < 1024; w++)
        do_write(i, w, 32'(w + 1) * 32'h9E37_79B9, 1'b0);
      read_all(i, "");
    end

    // R3: set then clear aliases
    do_write(0, 1, 32'h0000_F0F0, 1'b0);
    do_write(0, 2, 32'h0000_30C0, 1'b0);
    do_read(0, 0, "R3 status");
    do_write(0, 0, 32'hFFFF_FFFF, 1'b0);
    do_read(0, 0, "R3 status ro");

    // R4: only bit 9 requests reset
    do_write(0, 'h42, 32'hFFFF_FDFF, 1'b0);
    do_write(0, 'h42, 32'h0000_0200, 1'b0);
    do_write(1, 'h42, 32'h0000_0200, 1'b0);

    // R5: every old/new pair of the two release bits
    for (int i = 0; i < 2; i++)
      for (int o = 0; o < 4; o++)
        for (int n = 0; n < 4; n++) begin
          do_write(i, 'h46, 32'(o), 1'b0);
          do_write(i, 'h46, 32'h5A00 | 32'(n), 1'b0);
          do_read(i, 'h46, "R5 hold");
        end

    // R6: vector base writes
    do_write(0, 'h44, 32'h0012_3400, 1'b0);
    do_write(0, 'h45, 32'h0056_7800, 1'b0);
    do_write(1, 'h45, 32'h0056_7800, 1'b0);

    // R10: warm reset colliding with writes
    do_write(0, 'h43, 32'hC0DE_0001, 1'b0);
    do_write(0, 'h43, 32'hBEEF_0002, 1'b1);
    do_write(0, 'h41, 32'h0000_00FF, 1'b1);
    read_all(0, "R10 after warm");
    do_write(1, 'h43, 32'h1357_9BDF, 1'b0);
    do_write(1, 'h48, 32'h0000_0003, 1'b1);
    read_all(1, "R10 after warm base");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule